// File: doc/BRIEF.md
# Timer pin GPIO and capture interrupt unit

This block owns one external pin and lets software use it in one of two ways. As a general-purpose I/O, the pin can be driven high, driven low or released as an input. As an input-capture source, a chosen edge on the pin sets a sticky flag, and that flag can raise an interrupt request. Whichever mode is selected, the synchronised level of the pin can always be read.

Software controls the block through two 32-bit registers on a plain memory-mapped read/write port. The mode register sits at byte address 0x0 and the status register at 0x4. A write takes effect at the next clock edge. A read strobe loads the selected register into the read-data output at the next clock edge, and that output holds its value until the next read. There is only one interrupt source.

Top module: `tpin_unit`

## Requirements
- R1: After reset, both registers read as 0, `pin_oe` is 0 and `irq` is 0.
- R2: The mode register holds bits [2:0] (pin function), bits [5:4] (output control), bit 8 (interrupt enable) and bits [17:16] (capture edge). All other bits read as 0. When `rd_en` is high in a cycle, the register at `addr` appears on `rdata` after the next clock edge and stays there until the next read. An unmapped address reads as 0.
- R3: With mode bits [2:0] = 4 (GPIO), output control 2'b11 drives the pin high (`pin_oe`=1, `pin_out`=1). Output control 2'b10 drives it low (`pin_oe`=1, `pin_out`=0). Output control 2'b00 releases it (`pin_oe`=0).
- R4: With mode bits [2:0] = 1 (capture), or with any value other than 4, `pin_oe` is 0 whatever bits [5:4] hold.
- R5: In capture mode, the edge field [17:16] decides which edges set status bit 0: 2'b01 rising only, 2'b10 falling only, 2'b11 both, and 2'b00 none. An edge is a change of the synchronised pin level between consecutive cycles.
- R6: When mode bits [2:0] are not 1, no pin edge sets a status flag.
- R7: Writing a 1 to a status bit in [3:0] clears that bit. Writing a 0 leaves it unchanged.
- R8: When a capture edge and a write-one-to-clear of status bit 0 fall in the same cycle, bit 0 ends up set.
- R9: `irq` is 1 exactly when mode bit 8 is set and any of status bits [3:0] is set.
- R10: Status bit 8 reads back the synchronised pin level, which trails `pin_in` by two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte address (0x0 mode, 0x4 status) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| pin_in | input | 1 | Pin level from the pad |
| pin_out | output | 1 | Level driven onto the pin |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
A capture edge that sets status bit 0 and a software write that clears the same bit can land on the same clock edge. The bench provokes this by first setting the flag and then toggling the pin. It holds the clear write so that it meets the cycle in which the synchronised edge is seen, which is three clocks after the pin moves. A read then has to show the flag still set. A plain clear, made with no edge present, has to show it cleared.

// File: rtl/tpin_unit.sv
module tpin_unit #(
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          irq
);
  localparam logic [AW-1:0] ADDR_MODE = AW'(0);
  localparam logic [AW-1:0] ADDR_STAT = AW'(4);
  localparam logic [2:0]    SEL_CAP   = 3'd1;
  localparam logic [2:0]    SEL_GPIO  = 3'd4;

  logic [2:0]             sel;
  logic [1:0]             gpo;
  logic                   ien;
  logic [1:0]             edg;
  logic [3:0]             flags;
  logic [SYNC_STAGES-1:0] sync;
  logic                   prev;

  wire lvl     = sync[SYNC_STAGES-1];
  wire rise    = lvl & ~prev;
  wire fall    = ~lvl & prev;
  wire cap_evt = (sel == SEL_CAP) & ((edg[0] & rise) | (edg[1] & fall));
  wire wr_mode = wr_en & (addr == ADDR_MODE);
  wire wr_stat = wr_en & (addr == ADDR_STAT);

  wire [31:0] mode_word = {14'd0, edg, 7'd0, ien, 2'd0, gpo, 1'b0, sel};
  wire [31:0] stat_word = {23'd0, lvl, 4'd0, flags};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= '0;
      prev <= 1'b0;
    end else begin
      sync <= {sync[SYNC_STAGES-2:0], pin_in};
      prev <= lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= '0;
      gpo <= '0;
      ien <= 1'b0;
      edg <= '0;
    end else if (wr_mode) begin
      sel <= wdata[2:0];
      gpo <= wdata[5:4];
      ien <= wdata[8];
      edg <= wdata[17:16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      flags <= '0;
    else
      flags <= (flags & ~(wr_stat ? wdata[3:0] : 4'd0)) | {3'd0, cap_evt};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en) begin
      if (addr == ADDR_MODE)      rdata <= mode_word;
      else if (addr == ADDR_STAT) rdata <= stat_word;
      else                        rdata <= '0;
    end
  end

  assign pin_oe  = (sel == SEL_GPIO) & gpo[1];
  assign pin_out = pin_oe & gpo[0];
  assign irq     = ien & (|flags);
endmodule

// File: rtl/tpin_unit_chk.sv
module tpin_unit_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic [31:0]   rdata,
  input logic          pin_oe,
  input logic          irq,
  input logic [2:0]    sel,
  input logic          ien,
  input logic          flag0,
  input logic          cap_evt
);
  wire clr0 = wr_en & (addr == AW'(4)) & wdata[0];

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R2
  AST_OE_OFF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd1) |-> !pin_oe); // R4
  AST_NO_CAP_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag0 && sel != 3'd1) |=> !flag0); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag0 && !clr0) |=> flag0); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag0); // R8
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien); // R9
endmodule

bind tpin_unit tpin_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pin_oe(pin_oe), .irq(irq), .sel(sel),
  .ien(ien), .flag0(flags[0]), .cap_evt(cap_evt)
);

// File: tb/tpin_unit_tb.sv
module tpin_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pin_in = 1'b0;
  logic        pin_out, pin_oe, irq;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  tpin_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic [31:0] mw(input int s, input int g, input int e, input int ed);
    return 32'(s) | (32'(g) << 4) | (32'(e) << 8) | (32'(ed) << 16);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); pin_in = v;
    wait_cyc(4);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d); chk(d == 0, "R1 mode", d, 0);
    rd(4'h4, d); chk(d == 0, "R1 status", d, 0);
    chk(pin_oe == 0, "R1 oe", 32'(pin_oe), 0);
    chk(irq == 0, "R1 irq", 32'(irq), 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk(d == 32'h0003_0137, "R2 mode mask", d, 32'h0003_0137);
    wait_cyc(2); chk(rdata == 32'h0003_0137, "R2 rdata hold", rdata, 32'h0003_0137);
    rd(4'h8, d); chk(d == 0, "R2 unmapped", d, 0);
    wr(4'h0, 0);
  endtask

  task automatic t_gpio;
    wr(4'h0, mw(4, 3, 0, 0));
    chk(pin_oe == 1 && pin_out == 1, "R3 high", {30'd0, pin_oe, pin_out}, 3);
    wr(4'h0, mw(4, 2, 0, 0));
    chk(pin_oe == 1 && pin_out == 0, "R3 low", {30'd0, pin_oe, pin_out}, 2);
    wr(4'h0, mw(4, 0, 0, 0));
    chk(pin_oe == 0, "R3 release", 32'(pin_oe), 0);
    wr(4'h0, mw(1, 3, 0, 0));
    chk(pin_oe == 0, "R4 capture undriven", 32'(pin_oe), 0);
    wr(4'h0, mw(3, 3, 0, 0));
    chk(pin_oe == 0, "R4 other mode undriven", 32'(pin_oe), 0);
    wr(4'h0, 0);
  endtask

  task automatic t_edge(input int ed, input bit exp_r, input bit exp_f);
    logic [31:0] d;
    wr(4'h0, mw(1, 0, 0, ed));
    wr(4'h4, 32'hF);
    set_pin(1'b1);
    rd(4'h4, d); chk(d[0] == exp_r, $sformatf("R5 rise edge=%0d", ed), 32'(d[0]), 32'(exp_r));
    chk(d[8] == 1, "R10 level high", 32'(d[8]), 1);
    wr(4'h4, 32'hF);
    rd(4'h4, d); chk(d[3:0] == 0, "R7 clear", 32'(d[3:0]), 0);
    set_pin(1'b0);
    rd(4'h4, d); chk(d[0] == exp_f, $sformatf("R5 fall edge=%0d", ed), 32'(d[0]), 32'(exp_f));
    chk(d[8] == 0, "R10 level low", 32'(d[8]), 0);
    wr(4'h4, 32'hF);
  endtask

  task automatic t_nocap;
    logic [31:0] d;
    wr(4'h0, mw(4, 0, 1, 3));
    set_pin(1'b1); set_pin(1'b0);
    rd(4'h4, d); chk(d[3:0] == 0, "R6 gpio no capture", 32'(d[3:0]), 0);
    chk(irq == 0, "R6 irq idle", 32'(irq), 0);
  endtask

  task automatic t_w1c_irq;
    logic [31:0] d;
    wr(4'h0, mw(1, 0, 0, 1));
    set_pin(1'b1);
    chk(irq == 0, "R9 masked", 32'(irq), 0);
    wr(4'h0, mw(1, 0, 1, 1));
    chk(irq == 1, "R9 enabled", 32'(irq), 1);
    wr(4'h4, 32'hE);
    rd(4'h4, d); chk(d[0] == 1, "R7 write zero keeps", 32'(d[0]), 1);
    wr(4'h4, 32'h1);
    chk(irq == 0, "R9 after clear", 32'(irq), 0);
    set_pin(1'b0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    wr(4'h0, mw(1, 0, 1, 3));
    set_pin(1'b1);
    @(negedge clk); pin_in = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 4'h4; wdata = 32'h1;
    @(negedge clk); wr_en = 1'b0;
    wait_cyc(2);
    rd(4'h4, d); chk(d[0] == 1, "R8 set wins", 32'(d[0]), 1);
    wr(4'h4, 32'h1);
    rd(4'h4, d); chk(d[0] == 0, "R8 plain clear", 32'(d[0]), 0);
  endtask

  initial begin
    #(5 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_gpio();
    t_edge(1, 1, 0);
    t_edge(2, 0, 1);
    t_edge(3, 1, 1);
    t_edge(0, 0, 0);
    t_nocap();
    t_w1c_irq();
    t_set_wins();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule